// File: doc/BRIEF.md
# Theta Oscillation Stimulus Generator

This block drives the theta rhythm into a layer of recall neurons. It does not add a waveform sample to each membrane. Instead, it fires a number of unit-weight stimulus neurons, and each of those neurons reaches every recall neuron through a fixed weight of one quantization step. There are two stimulus groups. The amplitude group fires as many neurons as the amplitude the waveform had in the previous evaluation period. The delta group fires as many neurons as the size of the amplitude change from that period to the current one, and its sign flag picks the positive-weight bank or the negative-weight bank.

An evaluation period starts on each `tick` pulse. On that pulse the block steps a phase pointer through one theta cycle. The cycle holds a fixed number of periods, and the waveform is computed at elaboration from the `PERIOD` and `PEAK` parameters. The block also samples which recall neurons fire and reset in that period, because only those neurons take the amplitude term. This lets their potential restart from the current theta level, while all other recall neurons only follow the per-period change. For each recall neuron the block outputs the net stimulus it receives, in weight steps.

Top module: `theta_stim_gen`

## Requirements
- R1: A synchronous `rst` clears the following: `phase` goes to 0, `amp_cnt` to 0, `delta_mag` to 0, `delta_neg` to 0, and every bit of `amp_act`, `dpos_act`, `dneg_act`, `gate_out` and `stim_out` to zero. `rst` wins over a coincident `tick`.
- R2: The waveform sample at phase k is floor(PEAK*k/H) for k <= H, and floor(PEAK*(PERIOD-k)/H) otherwise, where H = PERIOD/2. With the defaults (PERIOD 66, PEAK 60), phase 33 holds the peak of 60.
- R3: Each `tick` advances `phase` by one, and the value after PERIOD-1 is 0. In a cycle without `tick`, no output changes.
- R4: One cycle after a `tick` at phase p, `amp_cnt` equals the sample at p. This is the previous period's amplitude.
- R5: After the same tick, `delta_mag` equals |sample(p') - sample(p)|, where p' is the new phase, and `delta_neg` is 1 exactly when the difference is negative. `delta_mag` never exceeds N_DELTA (6).
- R6: A positive nonzero delta sets bits [delta_mag-1:0] of `dpos_act` and clears all of `dneg_act`. A negative delta does the reverse. A zero delta activates neither group and leaves `delta_neg` at 0.
- R7: `amp_act` is a thermometer code: bit i is 1 exactly when i < `amp_cnt`.
- R8: `gate_out[i]` holds the value `fire_in[i]` had at the most recent `tick`. `fire_in` is ignored in cycles without `tick`.
- R9: `stim_out[SW*i +: SW]` is the two's-complement stimulus of recall neuron i, with SW = 8 by default. It equals (delta_neg ? -delta_mag : delta_mag) + (gate_out[i] ? amp_cnt : 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Start of an evaluation period |
| fire_in | input | N_RECALL | Recall neurons firing and resetting this period |
| phase | output | PH_W | Current phase within the theta cycle |
| amp_cnt | output | AMP_W | Number of active amplitude neurons |
| amp_act | output | PEAK | Amplitude neuron activations (thermometer) |
| delta_mag | output | DM_W | Number of active delta neurons |
| delta_neg | output | 1 | Delta sign, 1 selects the negative-weight group |
| dpos_act | output | N_DELTA | Positive-weight delta neuron activations |
| dneg_act | output | N_DELTA | Negative-weight delta neuron activations |
| gate_out | output | N_RECALL | Recall neurons taking the amplitude term |
| stim_out | output | N_RECALL*SW | Per-neuron net stimulus in weight steps |

## Verification
Several properties are checked on every cycle. The encoders are checked for thermometer shape and for a population count that matches the counts. The two delta groups must never be active together, the delta magnitude must stay within bound, and the phase must wrap after its last value. The amplitude output must follow a chain: each new amplitude is the old amplitude plus the old signed delta. The exact waveform values and the per-neuron stimulus sums can only be shown by the bench scenarios. The same holds for reset winning over a tick and for `fire_in` being ignored between ticks. The bench scenarios cover a full sweep through the wrap and a long run with random tick gaps and random fire patterns.

// File: rtl/theta_pkg.sv
package theta_pkg;

    // Triangular theta waveform, integer-quantized.
    function automatic int unsigned wave_sample(int unsigned k,
                                                int unsigned period,
                                                int unsigned peak);
        int unsigned half;
        half = period / 2;
        if (k >= period)
            return 0;
        else if (k <= half)
            return (peak * k) / half;
        else
            return (peak * (period - k)) / half;
    endfunction

endpackage

// File: rtl/theta_wave_lut.sv
module theta_wave_lut #(
    parameter int PERIOD = 66,
    parameter int PEAK   = 60,
    parameter int PH_W   = 7,
    parameter int AMP_W  = 6
) (
    input  logic [PH_W-1:0]  rd_a_phase,
    input  logic [PH_W-1:0]  rd_b_phase,
    output logic [AMP_W-1:0] rd_a_amp,
    output logic [AMP_W-1:0] rd_b_amp
);
    localparam int DEPTH = 2 ** PH_W;

    logic [AMP_W-1:0] tbl [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tbl
        assign tbl[g] = AMP_W'(theta_pkg::wave_sample(g, PERIOD, PEAK));
    end

    assign rd_a_amp = tbl[rd_a_phase];
    assign rd_b_amp = tbl[rd_b_phase];
endmodule

// File: rtl/theta_phase_seq.sv
module theta_phase_seq #(
    parameter int PERIOD   = 66,
    parameter int PEAK     = 60,
    parameter int N_DELTA  = 6,
    parameter int N_RECALL = 32,
    parameter int PH_W     = 7,
    parameter int AMP_W    = 6,
    parameter int DM_W     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic [N_RECALL-1:0] fire_in,
    output logic [PH_W-1:0]     phase_q,
    output logic [AMP_W-1:0]    amp_q,
    output logic [DM_W-1:0]     dmag_q,
    output logic                neg_q,
    output logic [N_RECALL-1:0] gate_q
);
    typedef struct packed {
        logic [PH_W-1:0]     phase;
        logic [AMP_W-1:0]    amp;
        logic [DM_W-1:0]     dmag;
        logic                neg;
        logic [N_RECALL-1:0] gate;
    } seq_t;

    seq_t cur_q, nxt_d;

    logic [PH_W-1:0]  phase_inc_d;
    logic [AMP_W-1:0] samp_cur, samp_nxt;
    logic [AMP_W-1:0] diff_full;

    assign phase_inc_d = (cur_q.phase == PH_W'(PERIOD - 1)) ? '0
                                                            : cur_q.phase + 1'b1;

    theta_wave_lut #(
        .PERIOD(PERIOD), .PEAK(PEAK), .PH_W(PH_W), .AMP_W(AMP_W)
    ) u_lut (
        .rd_a_phase(cur_q.phase),
        .rd_b_phase(phase_inc_d),
        .rd_a_amp  (samp_cur),
        .rd_b_amp  (samp_nxt)
    );

    assign diff_full = (samp_nxt >= samp_cur) ? (samp_nxt - samp_cur)
                                              : (samp_cur - samp_nxt);

    always_comb begin
        nxt_d = cur_q;
        if (rst) begin
            nxt_d = '0;
        end else if (tick) begin
            nxt_d.phase = phase_inc_d;
            nxt_d.amp   = samp_cur;
            nxt_d.dmag  = DM_W'(diff_full);
            nxt_d.neg   = (samp_nxt < samp_cur);
            nxt_d.gate  = fire_in;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign phase_q = cur_q.phase;
    assign amp_q   = cur_q.amp;
    assign dmag_q  = cur_q.dmag;
    assign neg_q   = cur_q.neg;
    assign gate_q  = cur_q.gate;

    // R5: the per-period step of the stored waveform fits in the delta group
    a_r5_step_fits: assert property (@(posedge clk) disable iff (rst)
        tick |-> (diff_full <= AMP_W'(N_DELTA)));

    // R3: phase wraps to zero after the last period of the cycle
    a_r3_phase_wrap: assert property (@(posedge clk) disable iff (rst)
        (tick && phase_q == PH_W'(PERIOD - 1)) |=> (phase_q == '0));

    // R3: no tick, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(phase_q) && $stable(amp_q) && $stable(dmag_q)
                   && $stable(neg_q) && $stable(gate_q)));

    // R4: new amplitude = old amplitude plus the old signed delta
    a_r4_amp_chain: assert property (@(posedge clk) disable iff (rst)
        tick |=> (amp_q == ($past(neg_q) ? $past(amp_q) - AMP_W'($past(dmag_q))
                                         : $past(amp_q) + AMP_W'($past(dmag_q)))));

    // R2: amplitude never exceeds the peak
    a_r2_amp_peak: assert property (@(posedge clk) disable iff (rst)
        amp_q <= AMP_W'(PEAK));
endmodule

// File: rtl/theta_therm_enc.sv
module theta_therm_enc #(
    parameter int N  = 60,
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] cnt,
    output logic [N-1:0]  vec
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign vec[i] = en && (cnt > CW'(i));
    end

    // R7 / R6: contiguous from bit 0
    a_r7_therm_shape: assert property (@(posedge clk) disable iff (rst)
        ((vec >> 1) & ~vec) == '0);

    // R7 / R6: population matches the count when enabled
    a_r7_therm_pop: assert property (@(posedge clk) disable iff (rst)
        en |-> ($countones(vec) == int'(cnt)));
endmodule

// File: rtl/theta_stim_gen.sv
module theta_stim_gen #(
    parameter int PERIOD   = 66,
    parameter int PEAK     = 60,
    parameter int N_DELTA  = 6,
    parameter int N_RECALL = 32,
    localparam int PH_W    = $clog2(PERIOD),
    localparam int AMP_W   = $clog2(PEAK + 1),
    localparam int DM_W    = $clog2(N_DELTA + 1),
    localparam int SW      = AMP_W + 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic [N_RECALL-1:0]    fire_in,
    output logic [PH_W-1:0]        phase,
    output logic [AMP_W-1:0]       amp_cnt,
    output logic [PEAK-1:0]        amp_act,
    output logic [DM_W-1:0]        delta_mag,
    output logic                   delta_neg,
    output logic [N_DELTA-1:0]     dpos_act,
    output logic [N_DELTA-1:0]     dneg_act,
    output logic [N_RECALL-1:0]    gate_out,
    output logic [N_RECALL*SW-1:0] stim_out
);
    logic [SW-1:0] dsig;

    theta_phase_seq #(
        .PERIOD(PERIOD), .PEAK(PEAK), .N_DELTA(N_DELTA), .N_RECALL(N_RECALL),
        .PH_W(PH_W), .AMP_W(AMP_W), .DM_W(DM_W)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .fire_in(fire_in),
        .phase_q(phase),
        .amp_q  (amp_cnt),
        .dmag_q (delta_mag),
        .neg_q  (delta_neg),
        .gate_q (gate_out)
    );

    theta_therm_enc #(.N(PEAK), .CW(AMP_W)) u_amp_enc (
        .clk(clk), .rst(rst), .en(1'b1), .cnt(amp_cnt), .vec(amp_act)
    );

    theta_therm_enc #(.N(N_DELTA), .CW(DM_W)) u_dpos_enc (
        .clk(clk), .rst(rst), .en(!delta_neg), .cnt(delta_mag), .vec(dpos_act)
    );

    theta_therm_enc #(.N(N_DELTA), .CW(DM_W)) u_dneg_enc (
        .clk(clk), .rst(rst), .en(delta_neg), .cnt(delta_mag), .vec(dneg_act)
    );

    assign dsig = delta_neg ? (SW'(0) - SW'(delta_mag)) : SW'(delta_mag);

    for (genvar i = 0; i < N_RECALL; i++) begin : g_stim
        assign stim_out[SW*i +: SW] = dsig + (gate_out[i] ? SW'(amp_cnt) : SW'(0));
    end

    // R6: only one delta group is ever active
    a_r6_groups_exclusive: assert property (@(posedge clk) disable iff (rst)
        !((|dpos_act) && (|dneg_act)));

    // R6: a zero delta carries no negative sign
    a_r6_zero_unsigned: assert property (@(posedge clk) disable iff (rst)
        (delta_mag == '0) |-> !delta_neg);

    // R5: delta never exceeds the group size
    a_r5_delta_bound: assert property (@(posedge clk) disable iff (rst)
        delta_mag <= DM_W'(N_DELTA));
endmodule

// File: tb/sim_theta_stim_gen.sv
`timescale 1ns/1ps
module sim_theta_stim_gen;
    localparam int PERIOD = 66, PEAK = 60, ND = 6, NR = 32;
    localparam int SW = 8;

    logic clk = 0, rst = 1, tick = 0;
    logic [NR-1:0] fire_in = '0;
    logic [6:0] phase;
    logic [5:0] amp_cnt;
    logic [PEAK-1:0] amp_act;
    logic [2:0] delta_mag;
    logic delta_neg;
    logic [ND-1:0] dpos_act, dneg_act;
    logic [NR-1:0] gate_out;
    logic [NR*SW-1:0] stim_out;

    int total = 0, bad = 0;
    int m_phase = 0, m_amp = 0, m_dmag = 0, m_neg = 0;
    logic [NR-1:0] m_gate = '0;
    bit done = 0;

    always #10 clk = ~clk;

    theta_stim_gen u0 (
        .clk(clk), .rst(rst), .tick(tick), .fire_in(fire_in),
        .phase(phase), .amp_cnt(amp_cnt), .amp_act(amp_act),
        .delta_mag(delta_mag), .delta_neg(delta_neg),
        .dpos_act(dpos_act), .dneg_act(dneg_act),
        .gate_out(gate_out), .stim_out(stim_out)
    );

    function automatic int wf(int k);
        int h = PERIOD / 2;
        return (k <= h) ? (PEAK * k) / h : (PEAK * (PERIOD - k)) / h;
    endfunction

    function automatic logic [63:0] therm(int n);
        logic [63:0] v = '0;
        for (int i = 0; i < n; i++) v[i] = 1'b1;
        return v;
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        int ds;
        chk(req == "" ? "R3" : req, "phase", 64'(phase), 64'(m_phase));
        chk(req == "" ? "R4" : req, "amp_cnt", 64'(amp_cnt), 64'(m_amp));
        chk("R5", "delta_mag", 64'(delta_mag), 64'(m_dmag));
        chk("R5", "delta_neg", 64'(delta_neg), 64'(m_neg));
        chk("R7", "amp_act", 64'(amp_act), therm(m_amp));
        chk("R6", "dpos_act", 64'(dpos_act), m_neg ? 64'd0 : therm(m_dmag));
        chk("R6", "dneg_act", 64'(dneg_act), m_neg ? therm(m_dmag) : 64'd0);
        chk("R8", "gate_out", 64'(gate_out), 64'(m_gate));
        ds = m_neg ? -m_dmag : m_dmag;
        for (int i = 0; i < NR; i++) begin
            int e = ds + (m_gate[i] ? m_amp : 0);
            chk("R9", "stim", 64'(stim_out[SW*i +: SW]), 64'(e[SW-1:0]));
        end
    endtask

    // Called at a negedge; applies inputs, updates the model at posedge,
    // checks at the following negedge.
    task automatic step(bit r, bit t, logic [NR-1:0] f, string req);
        rst = r; tick = t; fire_in = f;
        @(posedge clk);
        if (r) begin
            m_phase = 0; m_amp = 0; m_dmag = 0; m_neg = 0; m_gate = '0;
        end else if (t) begin
            int np = (m_phase == PERIOD - 1) ? 0 : m_phase + 1;
            int d  = wf(np) - wf(m_phase);
            m_amp = wf(m_phase);
            m_neg = (d < 0);
            m_dmag = (d < 0) ? -d : d;
            m_gate = f;
            m_phase = np;
        end
        @(negedge clk);
        check_all(req);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int seed = 7;
        void'($urandom(seed));
        @(negedge clk);
        // R1: reset state
        step(1, 0, '1, "R1");
        step(1, 1, '1, "R1");
        // R2 / R3: full directed sweep through the wrap
        for (int k = 0; k < PERIOD + 4; k++) begin
            step(0, 1, (k % 3 == 0) ? '1 : 32'h0F0F_1234, "R2");
            if (m_phase == 34) chk("R2", "peak sample", 64'(amp_cnt), 64'd60);
        end
        // R3 / R8: no tick, fire_in ignored
        step(0, 0, '1, "R3");
        step(0, 0, '0, "R3");
        // R1: reset wins over tick mid-cycle
        step(1, 1, '1, "R1");
        // Random phase
        for (int n = 0; n < 3000; n++) begin
            bit t = ($urandom % 2) == 0;
            bit r = ($urandom % 400) == 0;
            step(r, t, $urandom, "");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule